// File: doc/BRIEF.md
# Rate-Matching Interleaver and Bit Selector

This block takes the three output streams of a rate-1/3 turbo-style encoder (one systematic stream and two parity streams, each D bits long) and turns them into a transmit bit sequence of a requested length E. Each stream is conceptually placed row by row into a matrix of 32 columns. The matrix has just enough rows to hold D bits, and the unused cells at the front are filled with null markers. The matrix is then read column by column in a fixed column order.

The three interleaved streams form a virtual ring. The systematic stream comes first, followed by the two parity streams taken alternately one bit at a time. A redundancy-version input selects the start point on the ring. From there the block emits exactly E real bits, steps over null cells without counting them, and wraps back to the start of the ring as often as needed.

Software or an upstream engine first writes the three streams into the block's internal bit RAMs, one address at a time, with all three streams sharing each write. It then pulses `start` with D, E and the redundancy version. The block streams out one bit per non-null ring position, with a valid flag and a last flag.

Top module: `ratematch_selector`

## Requirements
- R1: After reset `busy`, `bitValid`, `bitLast` and `rvErr` are all low.
- R2: The row count is R = ceil(D/32), the stream length after padding is K = 32·R, and N = K−D nulls lead the matrix. Output index k of an interleaved stream reads matrix cell y = 32·(k mod R) + P(floor(k/R)). Here P(c) is the 5-bit bit-reversal of c, which gives the order 0,16,8,24,... Cell y is null when y < N and otherwise holds stream bit y−N.
- R3: Ring position j < K reads the systematic stream at k = j. For j ≥ K, let m = j−K. Even m reads the first parity stream at k = m/2, and odd m reads the second parity stream at k = (m−1)/2. The ring length is 3K.
- R4: For the second parity stream only, the cell index is shifted by one: y = (32·(k mod R) + P(floor(k/R)) + 1) mod K.
- R5: The first ring position examined is k0 = R·(24·rv + 2). This is 2R for rvIdx = 0 and 50R for rvIdx = 2, with rvIdx a 2-bit input.
- R6: Exactly E bits are emitted, one per non-null position in ring order. Null positions produce no output and do not count toward E. `bitLast` is high together with `bitValid` on the E-th bit only, and `busy` drops on the same edge.
- R7: After ring position 3K−1 the read continues at position 0, so E may exceed the number of non-null bits left after k0, or 3D in total.
- R8: A `start` with rvIdx equal to 1 or 3 raises `rvErr` for exactly one cycle, leaves `busy` low and produces no output.
- R9: `start` is ignored while `busy` is high, and the sequence in progress is unchanged.
- R10: A `start` with E = 0 is accepted without error but produces no output and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the stream RAMs |
| wrAddr | input | ADDR_W | Stream bit index being written |
| wrBits | input | 3 | Bit 0 systematic, bit 1 first parity, bit 2 second parity |
| start | input | 1 | Begin a selection run (one-cycle pulse) |
| lenD | input | LEN_W | Stream length D, 1 to 32·MAX_ROWS |
| lenE | input | E_W | Number of bits to emit |
| rvIdx | input | 2 | Redundancy version, 0 or 2 valid |
| bitOut | output | 1 | Selected bit |
| bitValid | output | 1 | bitOut carries a bit |
| bitLast | output | 1 | Final bit of the run |
| busy | output | 1 | Run in progress |
| rvErr | output | 1 | One-cycle flag for an illegal rvIdx |

## Verification
A wrong row, column or region counter shows up at the ports as a wrong bit value, or as an extra or missing bit wherever nulls are involved. It appears within one column of R cycles of the fault, because every ring position is visited in a fixed order at one position per cycle. A wrong null count or a wrong parity-2 offset shifts whole runs of bits, so the bench compares every emitted bit against a model that computes each ring position directly with division and modulo. The bench sweeps padding cases at D near multiples of 32, both redundancy versions, and lengths that wrap the ring.

// File: rtl/rm_pkg.sv
package rm_pkg;

  typedef struct packed {
    logic capture;    // latch run parameters this edge
    logic emit;       // current ring position is real and is sent
    logic last;       // this emission is the final one
    logic parRegion;  // ring position lies in the parity part
    logic parSel;     // 0: first parity, 1: second parity
  } rmCtl_t;

  function automatic logic [4:0] colPerm(input logic [4:0] c);
    logic [4:0] r;
    for (int i = 0; i < 5; i++) r[i] = c[4-i];
    return r;
  endfunction

endpackage

// File: rtl/rm_ctrl.sv
module rm_ctrl #(
  parameter int ROW_W = 4,
  parameter int LEN_W = 9,
  parameter int E_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [LEN_W-1:0]   lenD,
  input  logic [E_W-1:0]     lenE,
  input  logic [1:0]         rvIdx,
  input  logic               isNull,
  output rm_pkg::rmCtl_t     ctl,
  output logic [4:0]         col,
  output logic [ROW_W-1:0]   row,
  output logic [ROW_W-1:0]   rows,
  output logic               busy,
  output logic               rvErr
);
  logic [LEN_W:0]   dPlus;
  logic [ROW_W-1:0] rowsIn;
  logic [E_W-1:0]   eLim;
  logic [E_W-1:0]   emitted;
  logic             parRegion;
  logic             parSel;
  logic             rvOk;
  logic             rowWrap;

  assign dPlus   = {1'b0, lenD} + (LEN_W+1)'(31);
  assign rowsIn  = ROW_W'(dPlus >> 5);
  assign rvOk    = (rvIdx == 2'd0) || (rvIdx == 2'd2);
  assign rowWrap = (row == ROW_W'(rows - 1'b1));

  always_comb begin
    ctl.capture   = !busy && start && rvOk && (lenE != '0);
    ctl.emit      = busy && !isNull;
    ctl.last      = ctl.emit && (emitted == E_W'(eLim - 1'b1));
    ctl.parRegion = parRegion;
    ctl.parSel    = parSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0; rvErr <= 1'b0; rows <= '0; eLim <= '0; emitted <= '0;
      row <= '0; col <= '0; parRegion <= 1'b0; parSel <= 1'b0;
    end else begin
      rvErr <= 1'b0;
      if (!busy) begin
        if (start && !rvOk) begin
          rvErr <= 1'b1;
        end else if (ctl.capture) begin
          busy    <= 1'b1;
          rows    <= rowsIn;
          eLim    <= lenE;
          emitted <= '0;
          row     <= '0;
          parSel  <= 1'b0;
          // ring start is always on a column boundary
          if (rvIdx == 2'd0) begin parRegion <= 1'b0; col <= 5'd2; end
          else               begin parRegion <= 1'b1; col <= 5'd9; end
        end
      end else begin
        if (ctl.emit) emitted <= emitted + 1'b1;
        if (ctl.last) busy <= 1'b0;
        if (!parRegion || parSel) begin
          parSel <= 1'b0;
          if (rowWrap) begin
            row <= '0;
            col <= col + 1'b1;
            if (col == 5'd31) parRegion <= !parRegion;
          end else begin
            row <= row + 1'b1;
          end
        end else begin
          parSel <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rm_datapath.sv
module rm_datapath #(
  parameter int MAX_ROWS = 8,
  parameter int ROW_W    = 4,
  parameter int LEN_W    = 9,
  parameter int ADDR_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [2:0]         wrBits,
  input  logic [LEN_W-1:0]   lenD,
  input  rm_pkg::rmCtl_t     ctl,
  input  logic [4:0]         col,
  input  logic [ROW_W-1:0]   row,
  input  logic [ROW_W-1:0]   rows,
  output logic               isNull,
  output logic               bitOut,
  output logic               bitValid,
  output logic               bitLast
);
  localparam int YW    = ROW_W + 5;
  localparam int DEPTH = 32 * MAX_ROWS;

  logic [LEN_W-1:0]  dReg;
  logic [YW-1:0]     kpi, yBase, yInc, yPos, nulls;
  logic [ADDR_W-1:0] dataIdx;
  logic [2:0]        bankRd;
  logic [1:0]        bankSel;

  assign kpi     = {rows, 5'b0};
  assign yBase   = {row, rm_pkg::colPerm(col)};
  assign yInc    = YW'(yBase + 1'b1);
  assign yPos    = (ctl.parRegion && ctl.parSel) ? ((yInc == kpi) ? '0 : yInc) : yBase;
  assign nulls   = YW'(kpi - YW'(dReg));
  assign isNull  = (yPos < nulls);
  assign dataIdx = ADDR_W'(yPos - nulls);
  assign bankSel = !ctl.parRegion ? 2'd0 : (ctl.parSel ? 2'd2 : 2'd1);

  for (genvar s = 0; s < 3; s++) begin : g_bank
    logic mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wrEn) mem[wrAddr] <= wrBits[s];
    end
    assign bankRd[s] = mem[dataIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dReg <= '0; bitOut <= 1'b0; bitValid <= 1'b0; bitLast <= 1'b0;
    end else begin
      if (ctl.capture) dReg <= lenD;
      bitValid <= ctl.emit;
      bitLast  <= ctl.last;
      bitOut   <= ctl.emit ? bankRd[bankSel] : 1'b0;
    end
  end
endmodule

// File: rtl/ratematch_selector.sv
module ratematch_selector #(
  parameter int MAX_ROWS = 8,
  parameter int E_W      = 16,
  localparam int ROW_W   = $clog2(MAX_ROWS + 1),
  localparam int ADDR_W  = $clog2(32 * MAX_ROWS),
  localparam int LEN_W   = $clog2(32 * MAX_ROWS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [2:0]        wrBits,
  input  logic              start,
  input  logic [LEN_W-1:0]  lenD,
  input  logic [E_W-1:0]    lenE,
  input  logic [1:0]        rvIdx,
  output logic              bitOut,
  output logic              bitValid,
  output logic              bitLast,
  output logic              busy,
  output logic              rvErr
);
  rm_pkg::rmCtl_t   ctl;
  logic [4:0]       col;
  logic [ROW_W-1:0] row, rows;
  logic             isNull;

  rm_ctrl #(.ROW_W(ROW_W), .LEN_W(LEN_W), .E_W(E_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .lenD(lenD), .lenE(lenE),
    .rvIdx(rvIdx), .isNull(isNull), .ctl(ctl), .col(col), .row(row),
    .rows(rows), .busy(busy), .rvErr(rvErr));

  rm_datapath #(.MAX_ROWS(MAX_ROWS), .ROW_W(ROW_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrBits(wrBits),
    .lenD(lenD), .ctl(ctl), .col(col), .row(row), .rows(rows),
    .isNull(isNull), .bitOut(bitOut), .bitValid(bitValid), .bitLast(bitLast));
endmodule

// File: rtl/rm_checker.sv
module rm_checker #(
  parameter int E_W = 16
) (
  input logic           clk,
  input logic           rstN,
  input logic           start,
  input logic [E_W-1:0] lenE,
  input logic [1:0]     rvIdx,
  input logic           bitValid,
  input logic           bitLast,
  input logic           busy,
  input logic           rvErr
);
  logic [E_W-1:0] eSeen, eTarget;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eSeen <= '0; eTarget <= '0;
    end else if (!busy && start && (rvIdx == 2'd0 || rvIdx == 2'd2) && lenE != '0) begin
      eSeen <= '0; eTarget <= lenE;
    end else if (bitValid) begin
      eSeen <= eSeen + 1'b1;
    end
  end

  assert_valid_in_run_R6: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> $past(busy));
  assert_last_is_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    bitLast |-> bitValid);
  assert_emit_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> (eSeen < eTarget));
  assert_end_on_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> bitLast);
  assert_rverr_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    rvErr |-> ($past(start) && !$past(busy) && ($past(rvIdx) == 2'd1 || $past(rvIdx) == 2'd3)));
  assert_rverr_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    rvErr |-> (!busy && !bitValid));
  assert_hold_while_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !bitLast && $past(busy)) |-> !rvErr);
endmodule

bind ratematch_selector rm_checker #(.E_W(E_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .lenE(lenE), .rvIdx(rvIdx),
  .bitValid(bitValid), .bitLast(bitLast), .busy(busy), .rvErr(rvErr));

// File: tb/ratematch_selector_tb.sv
module ratematch_selector_tb;
  localparam int MAXR = 8;
  localparam int KMAX = 32 * MAXR;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, start = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [2:0] wrBits = '0;
  logic [8:0] lenD = '0;
  logic [15:0] lenE = '0;
  logic [1:0] rvIdx = '0;
  logic bitOut, bitValid, bitLast, busy, rvErr;

  int checks = 0, errors = 0, cycles = 0;
  int gotCnt = 0, lastCnt = 0, lastPos = -1;
  bit gotBits [4096];
  bit expBits [4096];
  bit streams [3][KMAX];

  always #10 clk = ~clk;

  ratematch_selector u_dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrBits(wrBits), .start(start), .lenD(lenD), .lenE(lenE), .rvIdx(rvIdx),
    .bitOut(bitOut), .bitValid(bitValid), .bitLast(bitLast), .busy(busy), .rvErr(rvErr));

  always @(negedge clk) begin
    cycles++;
    if (bitValid) begin
      if (gotCnt < 4096) gotBits[gotCnt] = bitOut;
      if (bitLast) begin lastCnt++; lastPos = gotCnt; end
      gotCnt++;
    end
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int brev5(input int c);
    int r = 0;
    for (int i = 0; i < 5; i++) if (c[i]) r |= 1 << (4 - i);
    return r;
  endfunction

  // returns -1 for a null ring position, else the bit value
  function automatic int ringBit(input int d, input int j);
    int rr = (d + 31) / 32;
    int k = 32 * rr;
    int n = k - d;
    int s, idx, y;
    if (j < k) begin s = 0; idx = j; end
    else begin s = 1 + ((j - k) % 2); idx = (j - k) / 2; end
    y = 32 * (idx % rr) + brev5(idx / rr);
    if (s == 2) y = (y + 1) % k;
    if (y < n) return -1;
    return int'(streams[s][y - n]);
  endfunction

  task automatic runCase(input string tag, input int d, input int e, input int rv, input bit disturb);
    int rr = (d + 31) / 32;
    int ncb = 96 * rr;
    int j = rr * (24 * rv + 2);
    int made = 0;
    int bad = 0, firstBad = -1;
    int guard;
    while (made < e) begin
      int v = ringBit(d, j);
      if (v >= 0) begin expBits[made] = v[0]; made++; end
      j = (j + 1) % ncb;
    end
    gotCnt = 0; lastCnt = 0; lastPos = -1;
    @(negedge clk);
    lenD = 9'(d); lenE = 16'(e); rvIdx = 2'(rv); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      repeat (3) @(negedge clk);
      lenD = 9'd100; lenE = 16'd5; rvIdx = 2'd2; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (busy && guard < 4 * (e + ncb) + 50) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
    for (int i = 0; i < e && i < gotCnt; i++)
      if (gotBits[i] != expBits[i]) begin bad++; if (firstBad < 0) firstBad = i; end
    check({tag, " R6 bit count"}, gotCnt, e);
    check({tag, " R6 last position"}, lastPos, e - 1);
    check({tag, " R6 single last"}, lastCnt, 1);
    if (bad != 0)
      $display("  %s first mismatch at bit %0d", tag, firstBad);
    check({tag, " bit mismatches"}, bad, 0);
  endtask

  initial begin
    for (int s = 0; s < 3; s++)
      for (int i = 0; i < KMAX; i++)
        streams[s][i] = bit'(((i * 37 + s * 11 + (i >> 3)) ^ (i >> 2) ^ (i * s)) & 1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 valid after reset", int'(bitValid), 0);
    check("R1 last after reset", int'(bitLast), 0);
    check("R1 rvErr after reset", int'(rvErr), 0);

    for (int i = 0; i < KMAX; i++) begin
      wrEn = 1'b1; wrAddr = 8'(i);
      wrBits = {streams[2][i], streams[1][i], streams[0][i]};
      @(negedge clk);
    end
    wrEn = 1'b0;

    runCase("R2 D=64 rv0 systematic", 64, 40, 0, 0);
    runCase("R2 D=33 rv0 padding", 33, 20, 0, 0);
    runCase("R2 D=31 rv0", 31, 50, 0, 0);
    runCase("R3 D=32 rv0 into parity", 32, 96, 0, 0);
    runCase("R4 D=40 rv2 parity2 offset", 40, 60, 2, 0);
    runCase("R5 D=100 rv2 start", 100, 100, 2, 0);
    runCase("R5 D=70 rv0 single bit", 70, 1, 0, 0);
    runCase("R7 D=40 rv2 wrap", 40, 130, 2, 0);
    runCase("R7 D=1 rv0 tiny", 1, 7, 0, 0);
    runCase("R7 D=1 rv2 tiny", 1, 5, 2, 0);
    runCase("R7 D=255 rv0", 255, 300, 0, 0);
    runCase("R7 D=256 rv2 wrap", 256, 800, 2, 0);
    runCase("R9 D=40 rv0 restart ignored", 40, 60, 0, 1);

    for (int bv = 1; bv <= 3; bv += 2) begin
      int seen = 0;
      gotCnt = 0;
      @(negedge clk);
      lenD = 9'd40; lenE = 16'd10; rvIdx = 2'(bv); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R8 rvErr raised", int'(rvErr), 1);
      check("R8 stays idle", int'(busy), 0);
      @(negedge clk);
      check("R8 rvErr one cycle", int'(rvErr), 0);
      repeat (10) @(negedge clk);
      seen = gotCnt;
      check("R8 no output", seen, 0);
    end

    gotCnt = 0;
    @(negedge clk);
    lenD = 9'd40; lenE = 16'd0; rvIdx = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10 E=0 not busy", int'(busy), 0);
    check("R10 E=0 no error", int'(rvErr), 0);
    repeat (10) @(negedge clk);
    check("R10 E=0 no output", gotCnt, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule